// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit settles the outcome of one branch for a 32-bit load/store processor. Each cycle it takes a decoded branch and the machine state that branch depends on. That state is the current instruction address, the condition register, the count register and the link register. From these it produces four things: the taken decision and the next fetch address, an optional write-back of a decremented count, an optional write of the return address, and a static prediction hint. Results are registered and appear one clock after the branch is presented with `br_valid_i` high.

A 5-bit control field chooses which tests apply. It can ask for a test of one condition-register bit against a chosen value, a decrement and test of the counter, or both, and it can invert the default prediction. The target comes from one of three sources: the count register, the link register, or a displacement. A displacement is used either as an absolute address or as an offset from the branch address. Every target is word aligned.

Top module: `brn_resolve`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises with no branch presented, every output is 0.
- R2: When `bo_i[4]` is 0, the condition test passes only if `cr_i[bi_i]` equals `bo_i[3]`. Bit 0 of `cr_i` is its least significant bit. When `bo_i[4]` is 1, the condition register is ignored and this test passes.
- R3: On a conditional kind (1 = displacement, 2 = to count register, 3 = to link register) with `bo_i[2]` = 0, the unit asserts `ctr_we_o` and drives `ctr_o` = `ctr_i` - 1 (modulo 2^32). The only exception is the invalid form in R10. When `bo_i[2]` is 1, or the kind is 0 (unconditional), `ctr_we_o` is 0.
- R4: When a decrement is requested, the counter test looks at the decremented value. If `bo_i[1]` = 0 the test passes when that value is nonzero, and if `bo_i[1]` = 1 it passes when that value is zero. With `bo_i[2]` = 1 the counter test passes.
- R5: Kind 0 is always taken. A conditional kind is taken only when every requested test passes. A branch that is not taken gives `next_pc_o` = `pc_i` + 4.
- R6: A taken branch goes to one of three targets. Kind 2 goes to `ctr_i` and kind 3 goes to `lr_i`. Kinds 0 and 1 go to `disp_i` when `abs_i` = 1, and to `pc_i` + `disp_i` when `abs_i` = 0.
- R7: The low two bits of every target are forced to 0.
- R8: When `link_i` = 1, `lr_we_o` = 1 and `lr_o` = `pc_i` + 4, whether or not the branch is taken.
- R9: The default prediction has two cases. For kinds 0 and 1 it is taken when `disp_i` is negative and not taken otherwise. For kinds 2 and 3 it is not taken. `hint_o` is this default XOR `bo_i[0]`.
- R10: Kind 2 with `bo_i[2]` = 0 is an invalid form. For it the unit raises `bad_form_o`, writes no counter and does not take the branch.
- R11: Results appear one cycle after `br_valid_i` is high. A cycle with `br_valid_i` low yields `res_valid_o` = 0 and no write enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid_i | input | 1 | A branch is presented this cycle |
| pc_i | input | 32 | Address of the branch instruction |
| kind_i | input | 2 | 0 unconditional disp, 1 conditional disp, 2 cond to count, 3 cond to link |
| bo_i | input | 5 | Branch control field |
| bi_i | input | 5 | Condition bit index |
| disp_i | input | 32 | Sign-extended displacement |
| abs_i | input | 1 | Displacement is an absolute address |
| link_i | input | 1 | Write return address |
| cr_i | input | 32 | Condition register |
| ctr_i | input | 32 | Count register |
| lr_i | input | 32 | Link register |
| res_valid_o | output | 1 | Result valid |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 32 | Next fetch address |
| ctr_we_o | output | 1 | Count register write enable |
| ctr_o | output | 32 | New count value |
| lr_we_o | output | 1 | Link register write enable |
| lr_o | output | 32 | Return address to write |
| hint_o | output | 1 | Static prediction hint |
| bad_form_o | output | 1 | Invalid instruction form |

## Verification
The bound checker watches, on every cycle, the relations that hold regardless of the branch outcome. These are the latency and gating of the write enables, the return address, the decrement value, the sequential address of an untaken branch, target alignment, the always-taken unconditional kind, and the suppression effects of the invalid form. Whether the combined condition and counter tests decide the outcome correctly, and whether the predicted direction is correct, is shown only by the bench. It sweeps every control-field value across all kinds, condition-bit values, counter values near zero, displacement signs and both addressing modes, and compares each result against arithmetic expectations.

// File: rtl/brn_pkg.sv
package brn_pkg;
   typedef enum logic [1:0] {
      BK_JUMP      = 2'd0,
      BK_COND_DISP = 2'd1,
      BK_COND_CTR  = 2'd2,
      BK_COND_LR   = 2'd3
   } brn_kind_e;

   localparam int BO_W        = 5;
   localparam int BO_SKIP_CR  = 4;
   localparam int BO_CR_VAL   = 3;
   localparam int BO_SKIP_CNT = 2;
   localparam int BO_CNT_ZERO = 1;
   localparam int BO_FLIP     = 0;
endpackage

// File: rtl/brn_cond_eval.sv
module brn_cond_eval
   import brn_pkg::*;
#(
   parameter int AW  = 32,
   parameter int CRW = 32,
   localparam int BIW = $clog2(CRW)
) (
   input  brn_kind_e       kind,
   input  logic [BO_W-1:0] bo,
   input  logic [BIW-1:0]  bi,
   input  logic [CRW-1:0]  cr,
   input  logic [AW-1:0]   ctr,
   output logic            cond_ok,
   output logic            ctr_upd,
   output logic [AW-1:0]   ctr_dec,
   output logic            bad_form
);
   logic is_cond, cr_pass, cnt_pass, want_dec;

   always_comb begin
      is_cond  = (kind != BK_JUMP);
      want_dec = is_cond && !bo[BO_SKIP_CNT];
      bad_form = (kind == BK_COND_CTR) && !bo[BO_SKIP_CNT];
      ctr_dec  = ctr - AW'(1);
      ctr_upd  = want_dec && !bad_form;
      cr_pass  = bo[BO_SKIP_CR] || (cr[bi] == bo[BO_CR_VAL]);
      if (bo[BO_SKIP_CNT])
         cnt_pass = 1'b1;
      else if (bo[BO_CNT_ZERO])
         cnt_pass = (ctr_dec == '0);
      else
         cnt_pass = (ctr_dec != '0);
      cond_ok = !is_cond || (!bad_form && cr_pass && cnt_pass);
   end
endmodule

// File: rtl/brn_target_gen.sv
module brn_target_gen
   import brn_pkg::*;
#(
   parameter int AW         = 32,
   parameter int ALIGN_BITS = 2,
   parameter int INSN_BYTES = 4
) (
   input  brn_kind_e     kind,
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] disp,
   input  logic          abs_mode,
   input  logic [AW-1:0] ctr,
   input  logic [AW-1:0] lr,
   output logic [AW-1:0] target,
   output logic [AW-1:0] seq_pc
);
   localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);
   logic [AW-1:0] raw;

   always_comb begin
      seq_pc = pc + STEP;
      unique case (kind)
         BK_COND_CTR: raw = ctr;
         BK_COND_LR:  raw = lr;
         default:     raw = abs_mode ? disp : (pc + disp);
      endcase
   end

   generate
      if (ALIGN_BITS > 0) begin : g_align
         assign target = {raw[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      end else begin : g_noalign
         assign target = raw;
      end
   endgenerate
endmodule

// File: rtl/brn_predict.sv
module brn_predict
   import brn_pkg::*;
(
   input  brn_kind_e       kind,
   input  logic [BO_W-1:0] bo,
   input  logic            disp_neg,
   output logic            hint
);
   logic dflt;
   always_comb begin
      dflt = ((kind == BK_JUMP) || (kind == BK_COND_DISP)) && disp_neg;
      hint = dflt ^ bo[BO_FLIP];
   end
endmodule

// File: rtl/brn_resolve.sv
module brn_resolve
   import brn_pkg::*;
#(
   parameter int AW         = 32,
   parameter int CRW        = 32,
   parameter int ALIGN_BITS = 2,
   parameter int INSN_BYTES = 4,
   localparam int BIW = $clog2(CRW)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            br_valid_i,
   input  logic [AW-1:0]   pc_i,
   input  logic [1:0]      kind_i,
   input  logic [4:0]      bo_i,
   input  logic [BIW-1:0]  bi_i,
   input  logic [AW-1:0]   disp_i,
   input  logic            abs_i,
   input  logic            link_i,
   input  logic [CRW-1:0]  cr_i,
   input  logic [AW-1:0]   ctr_i,
   input  logic [AW-1:0]   lr_i,
   output logic            res_valid_o,
   output logic            taken_o,
   output logic [AW-1:0]   next_pc_o,
   output logic            ctr_we_o,
   output logic [AW-1:0]   ctr_o,
   output logic            lr_we_o,
   output logic [AW-1:0]   lr_o,
   output logic            hint_o,
   output logic            bad_form_o
);
   generate
      if (AW < 8) begin : g_bad_aw
         $error("brn_resolve: AW must be at least 8");
      end
      if (CRW != (1 << BIW)) begin : g_bad_crw
         $error("brn_resolve: CRW must be a power of two");
      end
      if (ALIGN_BITS < 0 || ALIGN_BITS >= AW) begin : g_bad_align
         $error("brn_resolve: ALIGN_BITS out of range");
      end
   endgenerate

   brn_kind_e     kind;
   logic          cond_ok, ctr_upd, bad_form, hint;
   logic [AW-1:0] ctr_dec, target, seq_pc;

   assign kind = brn_kind_e'(kind_i);

   brn_cond_eval #(.AW(AW), .CRW(CRW)) u_cond (
      .kind(kind), .bo(bo_i), .bi(bi_i), .cr(cr_i), .ctr(ctr_i),
      .cond_ok(cond_ok), .ctr_upd(ctr_upd), .ctr_dec(ctr_dec),
      .bad_form(bad_form)
   );

   brn_target_gen #(.AW(AW), .ALIGN_BITS(ALIGN_BITS), .INSN_BYTES(INSN_BYTES)) u_tgt (
      .kind(kind), .pc(pc_i), .disp(disp_i), .abs_mode(abs_i),
      .ctr(ctr_i), .lr(lr_i), .target(target), .seq_pc(seq_pc)
   );

   brn_predict u_pred (
      .kind(kind), .bo(bo_i), .disp_neg(disp_i[AW-1]), .hint(hint)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid_o <= 1'b0;
         taken_o     <= 1'b0;
         next_pc_o   <= '0;
         ctr_we_o    <= 1'b0;
         ctr_o       <= '0;
         lr_we_o     <= 1'b0;
         lr_o        <= '0;
         hint_o      <= 1'b0;
         bad_form_o  <= 1'b0;
      end else begin
         res_valid_o <= br_valid_i;
         taken_o     <= br_valid_i && cond_ok;
         next_pc_o   <= !br_valid_i ? '0 : (cond_ok ? target : seq_pc);
         ctr_we_o    <= br_valid_i && ctr_upd;
         ctr_o       <= br_valid_i ? ctr_dec : '0;
         lr_we_o     <= br_valid_i && link_i;
         lr_o        <= br_valid_i ? seq_pc : '0;
         hint_o      <= br_valid_i && hint;
         bad_form_o  <= br_valid_i && bad_form;
      end
   end
endmodule

// File: rtl/brn_resolve_chk.sv
module brn_resolve_chk #(
   parameter int AW  = 32,
   parameter int CRW = 32,
   localparam int BIW = $clog2(CRW)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           br_valid_i,
   input logic [AW-1:0]  pc_i,
   input logic [1:0]     kind_i,
   input logic [4:0]     bo_i,
   input logic [BIW-1:0] bi_i,
   input logic [AW-1:0]  disp_i,
   input logic           abs_i,
   input logic           link_i,
   input logic [CRW-1:0] cr_i,
   input logic [AW-1:0]  ctr_i,
   input logic [AW-1:0]  lr_i,
   input logic           res_valid_o,
   input logic           taken_o,
   input logic [AW-1:0]  next_pc_o,
   input logic           ctr_we_o,
   input logic [AW-1:0]  ctr_o,
   input logic           lr_we_o,
   input logic [AW-1:0]  lr_o,
   input logic           hint_o,
   input logic           bad_form_o
);
   a_r11_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o == $past(br_valid_i));

   a_r11_no_we_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid_o |-> (!ctr_we_o && !lr_we_o && !taken_o));

   a_r8_link_value: assert property (@(posedge clk) disable iff (!rst_n)
      lr_we_o |-> (lr_o == $past(pc_i) + AW'(4)));

   a_r8_link_enable: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |-> (lr_we_o == $past(link_i)));

   a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      ctr_we_o |-> (ctr_o == $past(ctr_i) - AW'(1)));

   a_r5_seq_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && !taken_o) |-> (next_pc_o == $past(pc_i) + AW'(4)));

   a_r5_uncond_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && $past(kind_i) == 2'd0) |-> (taken_o && !ctr_we_o));

   a_r7_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && taken_o) |-> (next_pc_o[1:0] == 2'b00));

   a_r6_ctr_target: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && taken_o && $past(kind_i) == 2'd2) |->
         (next_pc_o == {$past(ctr_i[AW-1:2]), 2'b00}));

   a_r10_bad_form: assert property (@(posedge clk) disable iff (!rst_n)
      bad_form_o |-> (!ctr_we_o && !taken_o));
endmodule

bind brn_resolve brn_resolve_chk #(.AW(AW), .CRW(CRW)) u_chk (.*);

// File: tb/sim_brn_resolve.sv
`timescale 1ns/1ps
module sim_brn_resolve;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        br_valid_i = 1'b0;
   logic [31:0] pc_i = '0;
   logic [1:0]  kind_i = '0;
   logic [4:0]  bo_i = '0;
   logic [4:0]  bi_i = '0;
   logic [31:0] disp_i = '0;
   logic        abs_i = 1'b0;
   logic        link_i = 1'b0;
   logic [31:0] cr_i = '0;
   logic [31:0] ctr_i = '0;
   logic [31:0] lr_i = '0;
   logic        res_valid_o, taken_o, ctr_we_o, lr_we_o, hint_o, bad_form_o;
   logic [31:0] next_pc_o, ctr_o, lr_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   brn_resolve u0 (.*);

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   task automatic run_one(input logic [1:0] k, input logic [4:0] bo,
                          input logic [4:0] bi, input logic [31:0] cr,
                          input logic [31:0] ctr, input logic [31:0] disp,
                          input logic ab, input logic lk);
      logic [31:0] pc, lr, seq, tgt, dec, e_next;
      logic crp, cnp, bad, cond, tk, dflt, e_ctrwe;
      pc  = 32'h0001_2340;
      lr  = 32'h0BAD_F00F;
      seq = pc + 32'd4;
      dec = ctr - 32'd1;
      bad = (k == 2'd2) && !bo[2];
      crp = bo[4] || (cr[bi] == bo[3]);
      cnp = bo[2] || (bo[1] ? (dec == 0) : (dec != 0));
      cond = (k == 2'd0) || (!bad && crp && cnp);
      e_ctrwe = (k != 2'd0) && !bo[2] && !bad;
      case (k)
         2'd2:    tgt = ctr;
         2'd3:    tgt = lr;
         default: tgt = ab ? disp : pc + disp;
      endcase
      tgt[1:0] = 2'b00;
      e_next = cond ? tgt : seq;
      dflt = (k < 2'd2) && disp[31];
      @(negedge clk);
      br_valid_i = 1'b1; pc_i = pc; kind_i = k; bo_i = bo; bi_i = bi;
      disp_i = disp; abs_i = ab; link_i = lk; cr_i = cr; ctr_i = ctr; lr_i = lr;
      @(negedge clk);
      br_valid_i = 1'b0;
      chk("R11", "res_valid", 32'(res_valid_o), 32'd1);
      chk(k == 0 ? "R5" : (bo[4] ? "R4" : "R2"), "taken", 32'(taken_o), 32'(cond));
      chk(cond ? (k > 1 ? "R6" : "R7") : "R5", "next_pc", next_pc_o, e_next);
      chk("R3", "ctr_we", 32'(ctr_we_o), 32'(e_ctrwe));
      if (e_ctrwe) chk("R3", "ctr_value", ctr_o, dec);
      chk("R8", "lr_we", 32'(lr_we_o), 32'(lk));
      if (lk) chk("R8", "lr_value", lr_o, seq);
      chk("R9", "hint", 32'(hint_o), 32'(dflt ^ bo[0]));
      chk("R10", "bad_form", 32'(bad_form_o), 32'(bad));
   endtask

   initial begin
      logic [31:0] ctrv [3];
      logic [31:0] dispv [2];
      ctrv[0] = 32'd1; ctrv[1] = 32'd2; ctrv[2] = 32'd0;
      dispv[0] = 32'h0000_0126; dispv[1] = 32'hFFFF_FF02;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "res_valid in reset", 32'(res_valid_o), 32'd0);
      chk("R1", "next_pc in reset", next_pc_o, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "taken after reset", 32'(taken_o), 32'd0);
      chk("R1", "lr_we after reset", 32'(lr_we_o), 32'd0);
      chk("R11", "idle res_valid", 32'(res_valid_o), 32'd0);
      for (int k = 0; k < 4; k++)
         for (int bo = 0; bo < 32; bo++)
            for (int bi = 0; bi < 4; bi++)
               for (int c = 0; c < 3; c++)
                  for (int d = 0; d < 2; d++)
                     for (int ab = 0; ab < 2; ab++)
                        for (int lk = 0; lk < 2; lk++)
                           run_one(2'(k), 5'(bo), 5'(bi + 28 * (bi / 3)),
                                   32'h9000_0006, ctrv[c], dispv[d], 1'(ab), 1'(lk));
      // R11: idle cycle after activity raises no enables
      @(negedge clk);
      chk("R11", "idle ctr_we", 32'(ctr_we_o), 32'd0);
      chk("R11", "idle lr_we", 32'(lr_we_o), 32'd0);
      finish_run();
   end
endmodule